// File: doc/BRIEF.md
# Video Mode Geometry Validator

This block turns the raw contents of a display controller's mode registers into a checked scan-out geometry. Its inputs are the enable bit, the colour depth, the visible and virtual widths, the visible height, and the horizontal and vertical pan offsets. It also reads the framebuffer byte-order flag and the configured size of video memory. From these it derives the pixel format, the bytes per pixel, the line stride, the start offset inside video memory and the size of the visible surface.

It also decides whether the resulting mode can be scanned out safely. Modes that are disabled, use an unsupported depth, are too small, or would read past the end of video memory are rejected. All results come out of one register stage.

The block keeps a snapshot of the last valid mode it accepted. It raises a single-cycle change pulse whenever a newly accepted mode differs from that snapshot, so that the display path can schedule a full-surface refresh.

Top module: `vmode_geom_check`

## Requirements
- R1: When `cfg_en` is low the mode is invalid. Whenever `mode_valid` is low, `mode_fmt`, `mode_bytepp`, `mode_width`, `mode_height`, `mode_stride`, `mode_offset` and `mode_size` are all zero.
- R2: Depth 16 gives format code 1 (RGB 5-6-5) at 2 bytes per pixel, whatever the byte-order flag. Depth 32 gives format code 2 (xRGB little-endian) at 4 bytes per pixel when `cfg_big_endian` is low, and format code 3 (xRGB big-endian) when it is high. Every other depth makes the mode invalid.
- R3: The effective line width is the larger of `cfg_vwidth` and `cfg_xres`. The stride is the effective width times the bytes per pixel.
- R4: The size is stride times height. The offset is `cfg_xpan` times bytes per pixel plus `cfg_ypan` times stride.
- R5: The mode is invalid when `cfg_xres` or `cfg_yres` is below 64. A value of exactly 64 is accepted.
- R6: The mode is invalid when offset plus size exceeds the rounded video memory size. Equality is accepted. The sum is formed without wraparound, even for the largest register values.
- R7: A memory configuration below 4 MiB (4194304 bytes) or above 256 MiB (268435456 bytes) makes every mode invalid. A configuration inside that range is rounded up to the next power of two before the bound check of R6.
- R8: All outputs are registered: inputs present before a rising edge are reflected on the outputs just after that edge, and not before it.
- R9: `mode_changed` is high for one cycle when an accepted mode differs in any output field from the last accepted mode. The first accepted mode after reset also raises it. An invalid interval leaves the snapshot untouched, so returning to the same mode raises no pulse.
- R10: During and right after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Display enable bit |
| cfg_depth | input | 16 | Colour depth in bits per pixel |
| cfg_xres | input | 16 | Visible width in pixels |
| cfg_yres | input | 16 | Visible height in lines |
| cfg_vwidth | input | 16 | Virtual line width in pixels |
| cfg_xpan | input | 16 | Horizontal pan offset in pixels |
| cfg_ypan | input | 16 | Vertical pan offset in lines |
| cfg_big_endian | input | 1 | Byte order of 32-bit pixels, high for big-endian |
| cfg_mem_bytes | input | 32 | Configured video memory size in bytes |
| mode_valid | output | 1 | Decoded mode is usable |
| mode_fmt | output | 2 | Pixel format code (0 none, 1 RGB565, 2 xRGB LE, 3 xRGB BE) |
| mode_bytepp | output | 3 | Bytes per pixel |
| mode_width | output | 16 | Visible width |
| mode_height | output | 16 | Visible height |
| mode_stride | output | 18 | Line stride in bytes |
| mode_offset | output | 35 | Start offset in bytes |
| mode_size | output | 34 | Surface size in bytes |
| mode_changed | output | 1 | One-cycle pulse on a new accepted mode |

## Verification
The bench places a surface that ends exactly on the rounded memory limit, and then shifts it by one pixel. A design with a strict comparison, or one that skips the power-of-two rounding, rejects the first case or accepts the second. It drives widths and heights of 63 and 64 and a virtual width below the visible width; an off-by-one threshold or a missing clamp shows up as a wrong valid flag or a short stride. A maximal mode whose size exceeds 32 bits is also applied, and truncated arithmetic would let it wrap under the limit and be accepted. Finally, the bench disables and re-enables one mode and toggles the byte order at 16 bpp, expecting no change pulse, and it expects a pulse on the first mode after reset. A snapshot that is cleared while the mode is invalid, or that compares raw registers, would pulse in the wrong places.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

  typedef enum logic [1:0] {
    PF_NONE    = 2'd0,
    PF_RGB565  = 2'd1,
    PF_XRGB_LE = 2'd2,
    PF_XRGB_BE = 2'd3
  } pix_fmt_e;

  localparam int unsigned BPP_W = 3;

endpackage

// File: rtl/vmode_rst_sync.sv
module vmode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) chain_q <= '0;
        else           chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/vmode_fmt_decode.sv
module vmode_fmt_decode
  import vmode_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic [DEPTH_W-1:0] depth,
  input  logic               big_endian,
  output pix_fmt_e           fmt,
  output logic [BPP_W-1:0]   bytepp,
  output logic               fmt_ok
);

  always_comb begin
    fmt    = PF_NONE;
    bytepp = '0;
    fmt_ok = 1'b0;
    case (depth)
      DEPTH_W'(16): begin
        // 5-6-5 layout is byte-order agnostic here
        fmt    = PF_RGB565;
        bytepp = BPP_W'(2);
        fmt_ok = 1'b1;
      end
      DEPTH_W'(32): begin
        fmt    = big_endian ? PF_XRGB_BE : PF_XRGB_LE;
        bytepp = BPP_W'(4);
        fmt_ok = 1'b1;
      end
      default: begin
        fmt    = PF_NONE;
        bytepp = '0;
        fmt_ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vmode_mem_ceil.sv
module vmode_mem_ceil #(
  parameter  int MEM_W    = 32,
  parameter  int MIN_LOG2 = 22,
  parameter  int MAX_LOG2 = 28,
  localparam int CEIL_W   = MAX_LOG2 + 1
) (
  input  logic [MEM_W-1:0]  cfg_bytes,
  output logic              in_range,
  output logic [CEIL_W-1:0] ceil_bytes
);

  localparam logic [MEM_W-1:0] LIMIT_LO = MEM_W'(1) << MIN_LOG2;
  localparam logic [MEM_W-1:0] LIMIT_HI = MEM_W'(1) << MAX_LOG2;

  logic [MEM_W-1:0] below;
  int               top_bit;

  always_comb begin
    in_range = (cfg_bytes >= LIMIT_LO) && (cfg_bytes <= LIMIT_HI);
    below    = cfg_bytes - MEM_W'(1);
    top_bit  = 0;
    for (int i = 0; i < MEM_W; i++) begin
      if (below[i]) top_bit = i;
    end
    // smallest power of two not below the configured size
    if (in_range) ceil_bytes = CEIL_W'(1) << (top_bit + 1);
    else          ceil_bytes = '0;
  end

endmodule

// File: rtl/vmode_geom_calc.sv
module vmode_geom_calc
  import vmode_pkg::*;
#(
  parameter  int COORD_W  = 16,
  parameter  int MIN_RES  = 64,
  localparam int STRIDE_W = COORD_W + 2,
  localparam int SIZE_W   = STRIDE_W + COORD_W,
  localparam int OFS_W    = SIZE_W + 1,
  localparam int END_W    = OFS_W + 1
) (
  input  logic [COORD_W-1:0]  xres,
  input  logic [COORD_W-1:0]  yres,
  input  logic [COORD_W-1:0]  vwidth,
  input  logic [COORD_W-1:0]  xpan,
  input  logic [COORD_W-1:0]  ypan,
  input  logic [BPP_W-1:0]    bytepp,
  output logic [STRIDE_W-1:0] stride,
  output logic [SIZE_W-1:0]   size,
  output logic [OFS_W-1:0]    offset,
  output logic [END_W-1:0]    span_end,
  output logic                res_ok
);

  logic [COORD_W-1:0] eff_width;
  logic [OFS_W-1:0]   pan_x_bytes;
  logic [OFS_W-1:0]   pan_y_bytes;

  always_comb begin
    eff_width   = (vwidth < xres) ? xres : vwidth;
    stride      = STRIDE_W'(eff_width) * STRIDE_W'(bytepp);
    size        = SIZE_W'(stride) * SIZE_W'(yres);
    pan_x_bytes = OFS_W'(xpan) * OFS_W'(bytepp);
    pan_y_bytes = OFS_W'(ypan) * OFS_W'(stride);
    offset      = pan_x_bytes + pan_y_bytes;
    span_end    = END_W'(offset) + END_W'(size);
    res_ok      = (xres >= COORD_W'(MIN_RES)) && (yres >= COORD_W'(MIN_RES));
  end

endmodule

// File: rtl/vmode_geom_check.sv
module vmode_geom_check
  import vmode_pkg::*;
#(
  parameter  int COORD_W      = 16,
  parameter  int DEPTH_W      = 16,
  parameter  int MEM_W        = 32,
  parameter  int MEM_MIN_LOG2 = 22,
  parameter  int MEM_MAX_LOG2 = 28,
  parameter  int MIN_RES      = 64,
  parameter  int RST_STAGES   = 2,
  localparam int STRIDE_W     = COORD_W + 2,
  localparam int SIZE_W       = STRIDE_W + COORD_W,
  localparam int OFS_W        = SIZE_W + 1,
  localparam int END_W        = OFS_W + 1,
  localparam int CEIL_W       = MEM_MAX_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic [DEPTH_W-1:0]  cfg_depth,
  input  logic [COORD_W-1:0]  cfg_xres,
  input  logic [COORD_W-1:0]  cfg_yres,
  input  logic [COORD_W-1:0]  cfg_vwidth,
  input  logic [COORD_W-1:0]  cfg_xpan,
  input  logic [COORD_W-1:0]  cfg_ypan,
  input  logic                cfg_big_endian,
  input  logic [MEM_W-1:0]    cfg_mem_bytes,
  output logic                mode_valid,
  output logic [1:0]          mode_fmt,
  output logic [BPP_W-1:0]    mode_bytepp,
  output logic [COORD_W-1:0]  mode_width,
  output logic [COORD_W-1:0]  mode_height,
  output logic [STRIDE_W-1:0] mode_stride,
  output logic [OFS_W-1:0]    mode_offset,
  output logic [SIZE_W-1:0]   mode_size,
  output logic                mode_changed
);

  localparam logic [MEM_W-1:0] MEM_HI = MEM_W'(1) << MEM_MAX_LOG2;
  localparam logic [MEM_W-1:0] MEM_LO = MEM_W'(1) << MEM_MIN_LOG2;

  logic rst_q_n;

  vmode_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  // ---------------------------------------------------------------- decode
  pix_fmt_e           dec_fmt;
  logic [BPP_W-1:0]   dec_bytepp;
  logic               dec_fmt_ok;

  vmode_fmt_decode #(.DEPTH_W(DEPTH_W)) u_fmt (
    .depth      (cfg_depth),
    .big_endian (cfg_big_endian),
    .fmt        (dec_fmt),
    .bytepp     (dec_bytepp),
    .fmt_ok     (dec_fmt_ok)
  );

  logic               mem_ok;
  logic [CEIL_W-1:0]  mem_ceil;

  vmode_mem_ceil #(
    .MEM_W    (MEM_W),
    .MIN_LOG2 (MEM_MIN_LOG2),
    .MAX_LOG2 (MEM_MAX_LOG2)
  ) u_mem (
    .cfg_bytes  (cfg_mem_bytes),
    .in_range   (mem_ok),
    .ceil_bytes (mem_ceil)
  );

  logic [STRIDE_W-1:0] g_stride;
  logic [SIZE_W-1:0]   g_size;
  logic [OFS_W-1:0]    g_offset;
  logic [END_W-1:0]    g_end;
  logic                g_res_ok;

  vmode_geom_calc #(.COORD_W(COORD_W), .MIN_RES(MIN_RES)) u_geom (
    .xres     (cfg_xres),
    .yres     (cfg_yres),
    .vwidth   (cfg_vwidth),
    .xpan     (cfg_xpan),
    .ypan     (cfg_ypan),
    .bytepp   (dec_bytepp),
    .stride   (g_stride),
    .size     (g_size),
    .offset   (g_offset),
    .span_end (g_end),
    .res_ok   (g_res_ok)
  );

  // ------------------------------------------------------------ next state
  logic                accept;
  logic [1:0]          nxt_fmt;
  logic [BPP_W-1:0]    nxt_bytepp;
  logic [COORD_W-1:0]  nxt_width;
  logic [COORD_W-1:0]  nxt_height;
  logic [STRIDE_W-1:0] nxt_stride;
  logic [OFS_W-1:0]    nxt_offset;
  logic [SIZE_W-1:0]   nxt_size;
  logic                nxt_differs;

  logic                have_last_q;
  logic [1:0]          last_fmt_q;
  logic [BPP_W-1:0]    last_bytepp_q;
  logic [COORD_W-1:0]  last_width_q;
  logic [COORD_W-1:0]  last_height_q;
  logic [STRIDE_W-1:0] last_stride_q;
  logic [OFS_W-1:0]    last_offset_q;
  logic [SIZE_W-1:0]   last_size_q;
  logic                snap_en;

  always_comb begin
    accept = cfg_en && dec_fmt_ok && mem_ok && g_res_ok &&
             (g_end <= END_W'(mem_ceil));
    if (accept) begin
      nxt_fmt    = dec_fmt;
      nxt_bytepp = dec_bytepp;
      nxt_width  = cfg_xres;
      nxt_height = cfg_yres;
      nxt_stride = g_stride;
      nxt_offset = g_offset;
      nxt_size   = g_size;
    end else begin
      nxt_fmt    = '0;
      nxt_bytepp = '0;
      nxt_width  = '0;
      nxt_height = '0;
      nxt_stride = '0;
      nxt_offset = '0;
      nxt_size   = '0;
    end
    nxt_differs = accept && (!have_last_q            ||
                             nxt_fmt    != last_fmt_q    ||
                             nxt_bytepp != last_bytepp_q ||
                             nxt_width  != last_width_q  ||
                             nxt_height != last_height_q ||
                             nxt_stride != last_stride_q ||
                             nxt_offset != last_offset_q ||
                             nxt_size   != last_size_q);
    snap_en = nxt_differs;
  end

  // ------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_valid   <= 1'b0;
      mode_fmt     <= '0;
      mode_bytepp  <= '0;
      mode_width   <= '0;
      mode_height  <= '0;
      mode_stride  <= '0;
      mode_offset  <= '0;
      mode_size    <= '0;
      mode_changed <= 1'b0;
    end else begin
      mode_valid   <= accept;
      mode_fmt     <= nxt_fmt;
      mode_bytepp  <= nxt_bytepp;
      mode_width   <= nxt_width;
      mode_height  <= nxt_height;
      mode_stride  <= nxt_stride;
      mode_offset  <= nxt_offset;
      mode_size    <= nxt_size;
      mode_changed <= nxt_differs;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      have_last_q   <= 1'b0;
      last_fmt_q    <= '0;
      last_bytepp_q <= '0;
      last_width_q  <= '0;
      last_height_q <= '0;
      last_stride_q <= '0;
      last_offset_q <= '0;
      last_size_q   <= '0;
    end else if (snap_en) begin
      have_last_q   <= 1'b1;
      last_fmt_q    <= nxt_fmt;
      last_bytepp_q <= nxt_bytepp;
      last_width_q  <= nxt_width;
      last_height_q <= nxt_height;
      last_stride_q <= nxt_stride;
      last_offset_q <= nxt_offset;
      last_size_q   <= nxt_size;
    end
  end

  // ------------------------------------------------------------ assertions
  a_r1_disabled_invalid: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cfg_en |=> !mode_valid);

  a_r1_zero_fields: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mode_valid |-> (mode_fmt == 2'd0 && mode_bytepp == '0 && mode_width == '0 &&
                     mode_height == '0 && mode_stride == '0 &&
                     mode_offset == '0 && mode_size == '0));

  a_r2_fmt_pairing: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_valid |-> ((mode_fmt == 2'd1 && mode_bytepp == BPP_W'(2)) ||
                    (mode_fmt >= 2'd2 && mode_bytepp == BPP_W'(4))));

  a_r2_bad_depth: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_depth != DEPTH_W'(16) && cfg_depth != DEPTH_W'(32)) |=> !mode_valid);

  a_r3_stride_covers_width: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_valid |-> (mode_stride >= STRIDE_W'(mode_width) * STRIDE_W'(mode_bytepp)));

  a_r5_min_res: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_valid |-> (mode_width >= COORD_W'(MIN_RES) && mode_height >= COORD_W'(MIN_RES)));

  a_r6_within_max_mem: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_valid |-> (END_W'(mode_offset) + END_W'(mode_size) <= END_W'(MEM_HI)));

  a_r7_mem_out_of_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_mem_bytes > MEM_HI || cfg_mem_bytes < MEM_LO) |=> !mode_valid);

  a_r9_pulse_needs_valid: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_changed |-> mode_valid);

endmodule

// File: tb/vmode_geom_check_tb.sv
`timescale 1ns/1ps
module vmode_geom_check_tb;

  localparam longint MIB = 64'd1 << 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en;
  logic [15:0] cfg_depth, cfg_xres, cfg_yres, cfg_vwidth, cfg_xpan, cfg_ypan;
  logic        cfg_big_endian;
  logic [31:0] cfg_mem_bytes;
  logic        mode_valid;
  logic [1:0]  mode_fmt;
  logic [2:0]  mode_bytepp;
  logic [15:0] mode_width, mode_height;
  logic [17:0] mode_stride;
  logic [34:0] mode_offset;
  logic [33:0] mode_size;
  logic        mode_changed;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  vmode_geom_check u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_en (cfg_en), .cfg_depth (cfg_depth),
    .cfg_xres (cfg_xres), .cfg_yres (cfg_yres), .cfg_vwidth (cfg_vwidth),
    .cfg_xpan (cfg_xpan), .cfg_ypan (cfg_ypan), .cfg_big_endian (cfg_big_endian),
    .cfg_mem_bytes (cfg_mem_bytes), .mode_valid (mode_valid), .mode_fmt (mode_fmt),
    .mode_bytepp (mode_bytepp), .mode_width (mode_width), .mode_height (mode_height),
    .mode_stride (mode_stride), .mode_offset (mode_offset), .mode_size (mode_size),
    .mode_changed (mode_changed)
  );

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit en, int depth, int xr, int yr, int vw, int xp, int yp,
                       bit be, longint mem);
    cfg_en         = en;
    cfg_depth      = 16'(depth);
    cfg_xres       = 16'(xr);
    cfg_yres       = 16'(yr);
    cfg_vwidth     = 16'(vw);
    cfg_xpan       = 16'(xp);
    cfg_ypan       = 16'(yp);
    cfg_big_endian = be;
    cfg_mem_bytes  = 32'(mem);
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic apply(bit en, int depth, int xr, int yr, int vw, int xp, int yp,
                       bit be, longint mem);
    @(negedge clk);
    drive(en, depth, xr, yr, vw, xp, yp, be, mem);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // expected mode straight from the requirement text
  task automatic run_case(string tag, bit en, int depth, int xr, int yr, int vw,
                          int xp, int yp, bit be, longint mem);
    longint bpp, fmt, ew, stride, size, ofs, pow;
    bit ok;
    apply(en, depth, xr, yr, vw, xp, yp, be, mem);
    bpp = (depth == 16) ? 2 : (depth == 32) ? 4 : 0;
    fmt = (depth == 16) ? 1 : (depth == 32) ? (be ? 3 : 2) : 0;
    ew = (vw < xr) ? longint'(xr) : longint'(vw);
    stride = ew * bpp;
    size = stride * yr;
    ofs = longint'(xp) * bpp + longint'(yp) * stride;
    pow = 1;
    while (pow < mem) pow = pow * 2;
    ok = en && bpp != 0 && mem >= 4 * MIB && mem <= 256 * MIB &&
         xr >= 64 && yr >= 64 && (ofs + size) <= pow;
    check({tag, " valid"}, longint'(mode_valid), longint'(ok));
    check({tag, " fmt"},    longint'(mode_fmt),    ok ? fmt : 0);
    check({tag, " bytepp"}, longint'(mode_bytepp), ok ? bpp : 0);
    check({tag, " width"},  longint'(mode_width),  ok ? longint'(xr) : 0);
    check({tag, " height"}, longint'(mode_height), ok ? longint'(yr) : 0);
    check({tag, " stride"}, longint'(mode_stride), ok ? stride : 0);
    check({tag, " offset"}, longint'(mode_offset), ok ? ofs : 0);
    check({tag, " size"},   longint'(mode_size),   ok ? size : 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 reset valid",   longint'(mode_valid), 0);
    check("R10 reset changed", longint'(mode_changed), 0);
    check("R10 reset stride",  longint'(mode_stride), 0);
    check("R10 reset size",    longint'(mode_size), 0);
  endtask

  task automatic t_enable();
    run_case("R1 enable clear", 0, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R1 enable set",   1, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R1 enable clear again", 0, 16, 800, 600, 0, 0, 0, 0, 16 * MIB);
  endtask

  task automatic t_formats();
    run_case("R2 depth16",     1, 16, 640, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R2 depth16 be",  1, 16, 640, 480, 0, 0, 0, 1, 16 * MIB);
    run_case("R2 depth32 le",  1, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R2 depth32 be",  1, 32, 640, 480, 0, 0, 0, 1, 16 * MIB);
    run_case("R2 depth24",     1, 24, 640, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R2 depth8",      1, 8,  640, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R2 depth0",      1, 0,  640, 480, 0, 0, 0, 0, 16 * MIB);
  endtask

  task automatic t_clamp();
    run_case("R3 wide virtual",  1, 32, 1024, 768, 2000, 0, 0, 0, 16 * MIB);
    run_case("R3 narrow virtual", 1, 32, 1024, 768, 100, 0, 0, 0, 16 * MIB);
    run_case("R3 equal virtual", 1, 16, 1024, 768, 1024, 0, 0, 0, 16 * MIB);
  endtask

  task automatic t_offset();
    run_case("R4 pan 16bpp", 1, 16, 640, 480, 800, 10, 3, 0, 16 * MIB);
    run_case("R4 pan 32bpp", 1, 32, 320, 200, 0, 7, 11, 1, 16 * MIB);
  endtask

  task automatic t_minres();
    run_case("R5 width 63",  1, 32, 63, 480, 0, 0, 0, 0, 16 * MIB);
    run_case("R5 height 63", 1, 32, 640, 63, 0, 0, 0, 0, 16 * MIB);
    run_case("R5 64x64",     1, 32, 64, 64, 0, 0, 0, 0, 16 * MIB);
  endtask

  task automatic t_bound();
    run_case("R6 end equals limit", 1, 32, 1024, 1024, 0, 0, 1024, 0, 5 * MIB);
    run_case("R6 end past limit",   1, 32, 1024, 1024, 0, 1, 1024, 0, 5 * MIB);
    run_case("R6 no wraparound",    1, 32, 65535, 65535, 0, 0, 0, 0, 256 * MIB);
    run_case("R6 huge pan",         1, 32, 64, 64, 65535, 65535, 65535, 0, 256 * MIB);
  endtask

  task automatic t_memcfg();
    run_case("R7 mem below min", 1, 16, 640, 480, 0, 0, 0, 0, 4 * MIB - 1);
    run_case("R7 mem at min",    1, 16, 640, 480, 0, 0, 0, 0, 4 * MIB);
    run_case("R7 mem above max", 1, 16, 640, 480, 0, 0, 0, 0, 256 * MIB + 1);
    run_case("R7 min no round",  1, 32, 1024, 1024, 0, 0, 1024, 0, 4 * MIB);
    run_case("R7 max full",      1, 32, 4096, 4096, 0, 0, 12288, 0, 256 * MIB);
  endtask

  task automatic t_latency();
    apply(1, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    @(negedge clk);
    cfg_xres = 16'd800;
    #1;
    check("R8 before edge width", longint'(mode_width), 640);
    @(negedge clk);
    check("R8 after edge width", longint'(mode_width), 800);
    check("R8 after edge stride", longint'(mode_stride), 3200);
  endtask

  task automatic t_change();
    do_reset();
    apply(1, 16, 640, 480, 0, 0, 0, 0, 16 * MIB);
    check("R9 first after reset", longint'(mode_changed), 1);
    @(negedge clk);
    check("R9 steady no pulse", longint'(mode_changed), 0);
    apply(0, 16, 640, 480, 0, 0, 0, 0, 16 * MIB);
    check("R9 disabled no pulse", longint'(mode_changed), 0);
    apply(1, 16, 640, 480, 0, 0, 0, 0, 16 * MIB);
    check("R9 same mode back", longint'(mode_changed), 0);
    apply(1, 16, 640, 480, 0, 0, 0, 1, 16 * MIB);
    check("R9 R2 byte order ignored at 16bpp", longint'(mode_changed), 0);
    apply(1, 16, 640, 480, 0, 2, 0, 1, 16 * MIB);
    check("R9 pan change", longint'(mode_changed), 1);
    apply(1, 16, 640, 480, 0, 0, 0, 0, 16 * MIB);
    check("R9 back to first", longint'(mode_changed), 1);
    apply(1, 24, 320, 240, 0, 0, 0, 0, 16 * MIB);
    check("R9 invalid no pulse", longint'(mode_changed), 0);
    apply(1, 32, 640, 480, 0, 0, 0, 0, 16 * MIB);
    check("R9 depth change", longint'(mode_changed), 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_formats();
    t_clamp();
    t_offset();
    t_minres();
    t_bound();
    t_memcfg();
    t_latency();
    t_change();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule